// File: doc/BRIEF.md
# Two-Channel Capture/Compare Timer

A 16-bit up-counter paced by a power-of-two divider of the bus clock drives two independent channels. Each channel either records the counter on a chosen edge of its pin or acts on its pin when the counter reaches a stored value. The counter runs through its whole range or restarts after a programmable limit. Each wrap can toggle a channel pin, and both actions can raise sticky flags and interrupt requests.

Software reaches the block through a single-cycle register port. Reads return one cycle after the read strobe. A buffered PWM mode turns channel 0 into a pulse generator whose duty value alternates between the two channel value registers. A new duty value takes effect only at the start of a period.

Register map (3-bit address): 0 control, 1 status, 2 limit, 3 counter (read only), 4 channel 0 setup, 5 channel 0 value, 6 channel 1 setup, 7 channel 1 value.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the control register reads 0x0001 (frozen), and the status and counter read 0. Both pins are undriven (`chOe`=0) and no interrupt is raised.
- R2: Control bits [4:2] pick the divider exponent n. While the counter runs it advances once every 2^n bus cycles. A value of 7 acts as 6 (divide by 64).
- R3: With control bit 5 clear, the counter wraps from 0xFFFF to 0 and sets status bit 0.
- R4: With control bit 5 set, the counter wraps from the limit register value to 0 and sets status bit 0. It reaches the limit value itself without setting the flag.
- R5: Control bit 0 set freezes the counter and the divider. Writing 1 to control bit 1 clears both; that bit always reads 0.
- R6: In a channel setup register, bit 0 = 0 selects capture. Bits [2:1] select the edge: 01 rising, 10 falling, 11 either. The selected edge latches the counter into the channel value register and sets status bit 1 (channel 0) or bit 2 (channel 1). Other edges are ignored. Status bits clear when written with 1.
- R7: Setup bit 0 = 1 selects compare and drives the pin. On a counter step taken while the counter equals the channel value, the pin is acted on and the channel flag is set. Setup bits [4:3] pick the action: 01 set, 10 clear, 11 toggle.
- R8: In compare mode, setup bit 5 toggles the pin at every counter wrap.
- R9: Control bit 7 enables buffered PWM. Channel 0 is driven, goes high at each wrap and goes low at a duty match. The duty register in use switches at a wrap to whichever of the two value registers was written last, so a write during a period changes nothing until the next period.
- R10: `irqOvf` is high while status bit 0 and control bit 6 are both set. `irqCh[i]` is high while channel i's flag and its setup bit 6 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid the cycle after `rdEn` |
| chIn | input | 2 | Channel pin inputs |
| chOut | output | 2 | Channel pin output values |
| chOe | output | 2 | Channel pin output enables |
| irqOvf | output | 1 | Wrap interrupt request |
| irqCh | output | 2 | Per-channel interrupt requests |

## Verification
The embedded properties check on every cycle that a frozen counter holds its value and that every wrap lands on zero. They also check that a wrap in buffered PWM mode raises channel 0, that a set channel flag survives until software clears it, and that an enabled wrap raises the interrupt. The bench scenarios cover the rest: exact divider counts, the limit boundary, the full 16-bit wrap, capture values for each edge choice, and the set, clear and toggle actions. They also cover toggling on wrap and the period-aligned switch of the ping-pong duty registers, which need known stimulus and readback to show.

// File: rtl/ccTimerPkg.sv
package ccTimerPkg;
  localparam int NUM_CH = 2;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_STATUS = 1;
  localparam int ADR_LIMIT  = 2;
  localparam int ADR_COUNT  = 3;
  localparam int ADR_CHBASE = 4;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } cmpAct_e;

  typedef struct packed {
    logic       isCmp;
    logic [1:0] edgeSel;
    cmpAct_e    action;
    logic       ovfTgl;
    logic       ie;
  } chCfg_t;

  typedef struct packed {
    logic       stop;
    logic [2:0] psSel;
    logic       modEn;
    logic       ovfIe;
    logic       bufPwm;
  } tmrCfg_t;

  typedef struct packed {
    logic              cntClear;
    logic [NUM_CH-1:0] valWr;
  } strobe_t;
endpackage

// File: rtl/ccTimerCtrl.sv
module ccTimerCtrl
  import ccTimerPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [DATA_W-1:0]      cnt,
  input  logic [NUM_CH-1:0][DATA_W-1:0] chVal,
  input  logic                   ovfEvt,
  input  logic [NUM_CH-1:0]      chEvt,
  output tmrCfg_t                tmrCfg,
  output chCfg_t [NUM_CH-1:0]    chCfg,
  output strobe_t                stb,
  output logic [DATA_W-1:0]      limitVal,
  output logic [DATA_W-1:0]      rdData,
  output logic                   irqOvf,
  output logic [NUM_CH-1:0]      irqCh
);
  localparam int CFG_BITS = 7;

  logic              ovfFlag;
  logic [NUM_CH-1:0] chFlag;
  logic [DATA_W-1:0] clrBits;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    clrBits = (wrEn && addr == ADDR_W'(ADR_STATUS)) ? wrData : '0;
    stb.cntClear = wrEn && addr == ADDR_W'(ADR_CTRL) && wrData[1];
    for (int i = 0; i < NUM_CH; i++)
      stb.valWr[i] = wrEn && addr == ADDR_W'(ADR_CHBASE + 2 * i + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmrCfg   <= '{stop: 1'b1, default: '0};
      chCfg    <= '0;
      limitVal <= '0;
      ovfFlag  <= 1'b0;
      chFlag   <= '0;
    end else begin
      if (wrEn && addr == ADDR_W'(ADR_CTRL)) begin
        tmrCfg.stop   <= wrData[0];
        tmrCfg.psSel  <= wrData[4:2];
        tmrCfg.modEn  <= wrData[5];
        tmrCfg.ovfIe  <= wrData[6];
        tmrCfg.bufPwm <= wrData[7];
      end
      if (wrEn && addr == ADDR_W'(ADR_LIMIT)) limitVal <= wrData;
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrEn && addr == ADDR_W'(ADR_CHBASE + 2 * i)) begin
          chCfg[i].isCmp   <= wrData[0];
          chCfg[i].edgeSel <= wrData[2:1];
          chCfg[i].action  <= cmpAct_e'(wrData[4:3]);
          chCfg[i].ovfTgl  <= wrData[5];
          chCfg[i].ie      <= wrData[6];
        end
        chFlag[i] <= chEvt[i] | (chFlag[i] & ~clrBits[i+1]);
      end
      ovfFlag <= ovfEvt | (ovfFlag & ~clrBits[0]);
    end
  end

  always_comb begin
    rdNext = '0;
    if (addr == ADDR_W'(ADR_CTRL))
      rdNext = DATA_W'({tmrCfg.bufPwm, tmrCfg.ovfIe, tmrCfg.modEn, tmrCfg.psSel, 1'b0, tmrCfg.stop});
    else if (addr == ADDR_W'(ADR_STATUS))
      rdNext = DATA_W'({chFlag, ovfFlag});
    else if (addr == ADDR_W'(ADR_LIMIT))
      rdNext = limitVal;
    else if (addr == ADDR_W'(ADR_COUNT))
      rdNext = cnt;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(ADR_CHBASE + 2 * i))
        rdNext = {{(DATA_W - CFG_BITS){1'b0}}, chCfg[i].ie, chCfg[i].ovfTgl,
                  chCfg[i].action, chCfg[i].edgeSel, chCfg[i].isCmp};
      if (addr == ADDR_W'(ADR_CHBASE + 2 * i + 1))
        rdNext = chVal[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  always_comb begin
    irqOvf = ovfFlag & tmrCfg.ovfIe;
    for (int i = 0; i < NUM_CH; i++) irqCh[i] = chFlag[i] & chCfg[i].ie;
  end

  assert_irq_ovf_R10: assert property (@(posedge clk) disable iff (rst)
    (ovfEvt && tmrCfg.ovfIe && !(wrEn && addr == ADDR_W'(ADR_CTRL))) |=> irqOvf);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (chFlag[0] && !(wrEn && addr == ADDR_W'(ADR_STATUS) && wrData[1])) |=> chFlag[0]);
endmodule

// File: rtl/ccTimerDatapath.sv
module ccTimerDatapath
  import ccTimerPkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_SHIFT = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tmrCfg_t              tmrCfg,
  input  chCfg_t [NUM_CH-1:0]  chCfg,
  input  strobe_t              stb,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [CNT_W-1:0]     limitVal,
  input  logic [NUM_CH-1:0]    chIn,
  output logic [CNT_W-1:0]     cnt,
  output logic [NUM_CH-1:0][CNT_W-1:0] chVal,
  output logic [NUM_CH-1:0]    chOut,
  output logic [NUM_CH-1:0]    chOe,
  output logic                 ovfEvt,
  output logic [NUM_CH-1:0]    chEvt
);
  localparam int PS_W = MAX_SHIFT;
  localparam int SEL_W = $clog2(NUM_CH);

  logic [PS_W-1:0]  psCnt;
  logic [PS_W-1:0]  psMask;
  logic [2:0]       selEff;
  logic             advance;
  logic [CNT_W-1:0] topVal;
  logic [SEL_W-1:0] activeSel, pendSel;
  logic             pend;

  always_comb begin
    selEff  = (tmrCfg.psSel > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : tmrCfg.psSel;
    psMask  = ~({PS_W{1'b1}} << selEff);
    advance = !tmrCfg.stop && !stb.cntClear && ((psCnt & psMask) == psMask);
    topVal  = tmrCfg.modEn ? limitVal : '1;
    ovfEvt  = advance && (cnt == topVal);
  end

  always_ff @(posedge clk) begin
    if (rst || stb.cntClear) begin
      psCnt <= '0;
      cnt   <= '0;
    end else if (!tmrCfg.stop) begin
      psCnt <= psCnt + PS_W'(1);
      if (advance) cnt <= ovfEvt ? '0 : cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeSel <= '0;
      pendSel   <= '0;
      pend      <= 1'b0;
    end else begin
      if (ovfEvt && tmrCfg.bufPwm && pend) begin
        activeSel <= pendSel;
        pend      <= 1'b0;
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (stb.valWr[i]) begin
          pendSel <= SEL_W'(i);
          pend    <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam bit PWM_CH = (i == 0);
    logic [CNT_W-1:0] valR;
    logic sync1, sync2, prevIn, pinR;
    logic pwmMode, capHit, match, pinNext;

    always_comb begin
      pwmMode = PWM_CH && tmrCfg.bufPwm;
      capHit  = !chCfg[i].isCmp && !pwmMode &&
                ((chCfg[i].edgeSel[0] && sync2 && !prevIn) ||
                 (chCfg[i].edgeSel[1] && !sync2 && prevIn));
      match   = advance && (cnt == (pwmMode ? chVal[activeSel] : valR));
      pinNext = pinR;
      if (pwmMode) begin
        if (ovfEvt) pinNext = 1'b1;
        else if (match) pinNext = 1'b0;
      end else if (chCfg[i].isCmp) begin
        if (match) begin
          case (chCfg[i].action)
            ACT_SET: pinNext = 1'b1;
            ACT_CLR: pinNext = 1'b0;
            ACT_TGL: pinNext = ~pinR;
            default: pinNext = pinR;
          endcase
        end
        if (chCfg[i].ovfTgl && ovfEvt) pinNext = ~pinNext;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        {sync1, sync2, prevIn, pinR} <= '0;
        valR <= '0;
      end else begin
        sync1  <= chIn[i];
        sync2  <= sync1;
        prevIn <= sync2;
        pinR   <= pinNext;
        if (stb.valWr[i]) valR <= wrData;
        else if (capHit) valR <= cnt;
      end
    end

    assign chVal[i] = valR;
    assign chOut[i] = pinR;
    assign chOe[i]  = chCfg[i].isCmp || pwmMode;
    assign chEvt[i] = (chCfg[i].isCmp || pwmMode) ? match : capHit;
  end

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (tmrCfg.stop && !stb.cntClear) |=> $stable(cnt));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ovfEvt |=> (cnt == '0));

  assert_pwm_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (tmrCfg.bufPwm && ovfEvt) |=> chOut[0]);
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import ccTimerPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic [1:0]        chIn,
  output logic [1:0]        chOut,
  output logic [1:0]        chOe,
  output logic              irqOvf,
  output logic [1:0]        irqCh
);
  tmrCfg_t             tmrCfg;
  chCfg_t [NUM_CH-1:0] chCfg;
  strobe_t             stb;
  logic [CNT_W-1:0]    limitVal, cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] chVal;
  logic                ovfEvt;
  logic [NUM_CH-1:0]   chEvt;

  ccTimerCtrl #(.DATA_W(CNT_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .cnt(cnt), .chVal(chVal), .ovfEvt(ovfEvt), .chEvt(chEvt),
    .tmrCfg(tmrCfg), .chCfg(chCfg), .stb(stb), .limitVal(limitVal),
    .rdData(rdData), .irqOvf(irqOvf), .irqCh(irqCh)
  );

  ccTimerDatapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .tmrCfg(tmrCfg), .chCfg(chCfg), .stb(stb),
    .wrData(wrData), .limitVal(limitVal), .chIn(chIn),
    .cnt(cnt), .chVal(chVal), .chOut(chOut), .chOe(chOe),
    .ovfEvt(ovfEvt), .chEvt(chEvt)
  );
endmodule

// File: tb/test_capcmp_timer.sv
`timescale 1ns/1ps
module test_capcmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  chIn = '0;
  logic [1:0]  chOut, chOe, irqCh;
  logic        irqOvf;

  int checks = 0, fails = 0;
  logic [15:0] expVal[$];
  string       expTag[$];
  logic        readLaunched = 1'b0;
  logic [15:0] ctrlBase = '0;

  always #10 clk = ~clk;

  capcmp_timer i_capcmp_timer (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chIn(chIn), .chOut(chOut), .chOe(chOe),
    .irqOvf(irqOvf), .irqCh(irqCh)
  );

  // Monitor: pops the scoreboard when a read result appears.
  always @(posedge clk) readLaunched <= rdEn;
  always @(negedge clk) begin
    if (readLaunched && expVal.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expVal.pop_front();
      t = expTag.pop_front();
      checks++;
      if (rdData !== e) begin
        fails++;
        $display("FAIL %s: read actual 0x%04h expected 0x%04h", t, rdData, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [15:0] e, input string t);
    expVal.push_back(e);
    expTag.push_back(t);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic sigChk(input logic [3:0] act, input logic [3:0] e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, e);
    end
  endtask

  task automatic clearCnt();
    wr(3'd0, ctrlBase | 16'h0003);
  endtask

  task automatic run(input int k);
    wr(3'd0, ctrlBase);
    repeat (k - 1) @(negedge clk);
    wr(3'd0, ctrlBase | 16'h0001);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rdChk(3'd0, 16'h0001, "R1 control");
    rdChk(3'd1, 16'h0000, "R1 status");
    rdChk(3'd3, 16'h0000, "R1 counter");
    sigChk({2'b0, chOe}, 4'h0, "R1 oe");
    sigChk({1'b0, irqOvf, irqCh}, 4'h0, "R1 irq");

    // R2 divider
    ctrlBase = 16'h000C; clearCnt(); run(80);
    rdChk(3'd3, 16'd10, "R2 divide by 8");
    ctrlBase = 16'h0000; clearCnt(); run(37);
    rdChk(3'd3, 16'd37, "R2 divide by 1");
    ctrlBase = 16'h001C; clearCnt(); run(128);
    rdChk(3'd3, 16'd2, "R2 select 7 acts as 64");

    // R5 stop and clear
    repeat (20) @(negedge clk);
    rdChk(3'd3, 16'd2, "R5 frozen");
    clearCnt();
    rdChk(3'd3, 16'd0, "R5 cleared");
    rdChk(3'd0, 16'h001D, "R5 clear bit reads 0");

    // R4 limit
    wr(3'd2, 16'd9); wr(3'd1, 16'h0007);
    ctrlBase = 16'h0020; clearCnt(); run(9);
    rdChk(3'd3, 16'd9, "R4 reaches limit");
    rdChk(3'd1, 16'h0000, "R4 no flag at limit");
    run(1);
    rdChk(3'd3, 16'd0, "R4 wrap");
    rdChk(3'd1, 16'h0001, "R4 flag");
    run(3);
    rdChk(3'd3, 16'd3, "R4 after wrap");
    wr(3'd1, 16'h0001);
    rdChk(3'd1, 16'h0000, "R6 write-one clear");

    // R3 full range
    ctrlBase = 16'h0000; clearCnt(); run(65537);
    rdChk(3'd3, 16'd1, "R3 counter");
    rdChk(3'd1, 16'h0001, "R3 flag");

    // R10 wrap interrupt
    ctrlBase = 16'h0040; wr(3'd0, 16'h0041);
    sigChk({3'b0, irqOvf}, 4'h1, "R10 irqOvf on");
    wr(3'd1, 16'h0001);
    sigChk({3'b0, irqOvf}, 4'h0, "R10 irqOvf off");

    // R6 capture
    ctrlBase = 16'h0000; clearCnt(); wr(3'd1, 16'h0007);
    wr(3'd4, 16'h0042); wr(3'd6, 16'h0006);
    run(20);
    chIn[0] = 1'b1; settle();
    rdChk(3'd5, 16'd20, "R6 rising capture");
    rdChk(3'd1, 16'h0002, "R6 ch0 flag");
    sigChk({2'b0, irqCh}, 4'h1, "R10 irqCh0");
    wr(3'd1, 16'h0002);
    run(5);
    chIn[0] = 1'b0; settle();
    rdChk(3'd5, 16'd20, "R6 falling ignored");
    rdChk(3'd1, 16'h0000, "R6 no flag on ignored edge");
    chIn[1] = 1'b1; settle();
    rdChk(3'd7, 16'd25, "R6 any-edge rise");
    run(5);
    chIn[1] = 1'b0; settle();
    rdChk(3'd7, 16'd30, "R6 any-edge fall");
    rdChk(3'd1, 16'h0004, "R6 ch1 flag");

    // R7 compare actions
    ctrlBase = 16'h0020; clearCnt(); wr(3'd1, 16'h0007);
    wr(3'd4, 16'h0009); wr(3'd6, 16'h0019);
    wr(3'd5, 16'd5); wr(3'd7, 16'd5);
    sigChk({chOe, chOut}, 4'hC, "R7 driven low");
    run(5);
    sigChk({2'b0, chOut}, 4'h0, "R7 before match");
    run(1);
    sigChk({2'b0, chOut}, 4'h3, "R7 set and toggle");
    rdChk(3'd1, 16'h0006, "R7 flags");
    wr(3'd4, 16'h0011);
    run(9);
    sigChk({2'b0, chOut}, 4'h3, "R7 held between matches");
    run(1);
    sigChk({2'b0, chOut}, 4'h0, "R7 clear and toggle");

    // R8 toggle on wrap
    wr(3'd6, 16'h0021); clearCnt();
    run(10);
    sigChk({2'b0, chOut}, 4'h2, "R8 first wrap");
    run(10);
    sigChk({2'b0, chOut}, 4'h0, "R8 second wrap");

    // R9 buffered PWM
    wr(3'd4, 16'h0000); wr(3'd6, 16'h0000);
    ctrlBase = 16'h00A0; wr(3'd5, 16'd3); clearCnt();
    sigChk({2'b0, chOe}, 4'h1, "R9 oe");
    run(10);
    sigChk({3'b0, chOut[0]}, 4'h1, "R9 high at wrap");
    run(2);
    wr(3'd7, 16'd6);
    run(2);
    sigChk({3'b0, chOut[0]}, 4'h0, "R9 old duty kept mid-period");
    run(6);
    sigChk({3'b0, chOut[0]}, 4'h1, "R9 second period start");
    run(4);
    sigChk({3'b0, chOut[0]}, 4'h1, "R9 new duty not yet reached");
    run(3);
    sigChk({3'b0, chOut[0]}, 4'h0, "R9 new duty match");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule